// File: doc/BRIEF.md
# Run-Length Signal-Loss Detector and Clock-Lock Selector

This block sits beside a serial receiver's clock recovery. It is fed the recovered 10-bit parallel words one strobe at a time. It declares loss of signal when the line has stuck at one level for long enough that a whole run of words is uniform: every word all ones, or every word all zeros, with the same polarity throughout. A mixed word ends the run. The word-level run test is a coarse measure in serial bits. With 10-bit words and a run of 12 words, any stuck stretch of 129 bits or more always covers 12 whole words. A stretch of 119 bits or fewer never does. Stretches from 120 to 128 bits trip the flag or not, depending on where they fall against the word boundaries.

The loss result is combined with a frequency-OK indication from an external comparator. That comparator passes when the incoming data is within 400 ppm of the reference. The result drives a two-state selector that tells the clock recovery to track the data or to fall back to the reference clock. The selector has hysteresis. Leaving data lock takes a single failing word time. Re-entering data lock takes a streak of consecutive passing word times.

Top module: `los_lock_selector`

## Requirements
- R1: A word is uniform when it equals 10'h3FF or 10'h000. After the strobe that carries the 12th consecutive uniform word of the same value, `sigLoss` reads 1 on the following cycle. After only 11 such words it reads 0.
- R2: A serial run of 119 or fewer identical bits, placed at any bit offset within an otherwise alternating stream, never sets `sigLoss`.
- R3: A serial run of 129 or more identical bits, at any bit offset, always sets `sigLoss`.
- R4: A run of 120 to 128 bits sets `sigLoss` exactly when it covers 12 whole aligned words. A 120-bit run sets it when aligned and does not set it when shifted by one bit.
- R5: A uniform word of the opposite value restarts the run at one word. For example, 11 words of all ones followed by 11 words of all zeros leave `sigLoss` at 0, and one further all-zeros word sets it.
- R6: Once `sigLoss` is set, it stays set through further uniform words of either value. The first mixed word clears it and empties the run count.
- R7: After reset `lockData` is 0. It becomes 1 only after 4 consecutive strobes that each pass. A strobe passes when `freqOk` is 1 with the strobe and `sigLoss` was 0 before that strobe. A failing strobe restarts the streak.
- R8: While `lockData` is 1, the first failing strobe returns it to 0.
- R9: Cycles without `wordValid` change neither output, whatever `wordIn` and `freqOk` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Strobe: `wordIn` holds a new received word |
| wordIn | input | 10 | Recovered parallel word |
| freqOk | input | 1 | Frequency comparator pass, sampled with the strobe |
| sigLoss | output | 1 | Loss-of-signal flag from the run-length test |
| lockData | output | 1 | 1: recover clock from data; 0: use the reference clock |

## Verification
The hardest situation to reach from the ports is the boundary band between 119 and 129 bits. Whether a stuck stretch trips the flag depends on its phase against word boundaries, and word-aligned stimulus never shows that. The bench therefore builds a serial bit stream: an alternating background with one run of chosen length and offset. It packs that stream into words, sweeps every offset from 0 to 9 for lengths 119 and 129, and probes 120 both aligned and shifted. For each run it predicts the outcome by counting the whole words the run covers.

// File: rtl/los_lock_pkg.sv
package los_lock_pkg;
  // Strobes from the control module to the run-length datapath.
  typedef struct packed {
    logic start;     // begin a new run of one uniform word
    logic advance;   // extend the current run by one word
    logic clear;     // mixed word: empty the run and drop loss
    logic polarity;  // value of the uniform word (start only)
  } runStrobeT;

  typedef enum logic {
    LOCK_REF  = 1'b0,
    LOCK_DATA = 1'b1
  } lockStateT;
endpackage

// File: rtl/run_datapath.sv
module run_datapath
  import los_lock_pkg::*;
#(
  parameter int RUN_WORDS = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  runStrobeT strb,
  output logic      runActive,
  output logic      runPol,
  output logic      lossFlag
);
  localparam int CNT_W = $clog2(RUN_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_WORDS);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] cntNext;
  logic             polReg;

  always_comb begin
    cntNext = runCnt;
    if (strb.clear)        cntNext = '0;
    else if (strb.start)   cntNext = CNT_W'(1);
    else if (strb.advance) cntNext = (runCnt == CNT_MAX) ? runCnt : runCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt   <= '0;
      polReg   <= 1'b0;
      lossFlag <= 1'b0;
    end else begin
      runCnt <= cntNext;
      if (strb.start) polReg <= strb.polarity;
      if (strb.clear)                  lossFlag <= 1'b0;
      else if (cntNext == CNT_MAX)     lossFlag <= 1'b1;
    end
  end

  assign runActive = (runCnt != '0);
  assign runPol    = polReg;

  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= CNT_MAX);
  a_r1_trip_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && runCnt == CNT_MAX - CNT_W'(1)) |=> lossFlag);
  a_r6_mixed_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!lossFlag && !runActive));
  a_r6_loss_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !strb.clear) |=> lossFlag);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.start || strb.advance || strb.clear) |=> $stable(lossFlag));
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import los_lock_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int LOCK_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              freqOk,
  input  logic              runActive,
  input  logic              runPol,
  input  logic              lossFlag,
  output runStrobeT         strb,
  output logic              lockData
);
  localparam int HOLD_W = $clog2(LOCK_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(LOCK_HOLD - 1);

  logic      allOnes, allZeros, uniform, pass;
  lockStateT state;
  logic [HOLD_W-1:0] passCnt;

  assign allOnes  = &wordIn;
  assign allZeros = ~|wordIn;
  assign uniform  = allOnes | allZeros;
  assign pass     = freqOk & ~lossFlag;

  always_comb begin
    strb          = '0;
    strb.polarity = allOnes;
    if (wordValid) begin
      if (!uniform)                             strb.clear   = 1'b1;
      else if (runActive && runPol == allOnes)  strb.advance = 1'b1;
      else                                      strb.start   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= LOCK_REF;
      passCnt <= '0;
    end else if (wordValid) begin
      case (state)
        LOCK_REF: begin
          if (!pass) passCnt <= '0;
          else if (passCnt == HOLD_LAST) begin
            passCnt <= '0;
            state   <= LOCK_DATA;
          end else passCnt <= passCnt + HOLD_W'(1);
        end
        default: begin
          passCnt <= '0;
          if (!pass) state <= LOCK_REF;
        end
      endcase
    end
  end

  assign lockData = (state == LOCK_DATA);

  a_r7_enter_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockData) |-> ($past(passCnt) == HOLD_LAST && $past(pass)));
  a_r8_drop_on_fail: assert property (@(posedge clk) disable iff (!rstN)
    (lockData && wordValid && !pass) |=> !lockData);
  a_r9_lock_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(lockData));
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.start, strb.advance, strb.clear}) == (wordValid ? 1 : 0));
endmodule

// File: rtl/los_lock_selector.sv
module los_lock_selector
  import los_lock_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_WORDS = 12,
  parameter int LOCK_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              freqOk,
  output logic              sigLoss,
  output logic              lockData
);
  runStrobeT strb;
  logic      runActive, runPol, lossFlag;

  lock_ctrl #(.WORD_W(WORD_W), .LOCK_HOLD(LOCK_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .freqOk(freqOk), .runActive(runActive), .runPol(runPol),
    .lossFlag(lossFlag), .strb(strb), .lockData(lockData)
  );

  run_datapath #(.RUN_WORDS(RUN_WORDS)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .runActive(runActive),
    .runPol(runPol), .lossFlag(lossFlag)
  );

  assign sigLoss = lossFlag;
endmodule

// File: tb/los_lock_selector_bench.sv
`timescale 1ns/1ps
module los_lock_selector_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [9:0] wordIn = '0;
  logic freqOk = 1'b0;
  logic sigLoss, lockData;

  int nRun = 0;
  int nFail = 0;

  // requirement model state
  int   mCnt = 0;
  logic mPol = 1'b0;
  logic mLoss = 1'b0;
  logic mLock = 1'b0;
  int   mPass = 0;

  always #2 clk = ~clk;

  los_lock_selector u_los_lock_selector (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .freqOk(freqOk), .sigLoss(sigLoss), .lockData(lockData)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic modelStep(input logic [9:0] w, input logic f);
    logic pass, uni, pol;
    pass = f && !mLoss;
    if (mLock) begin
      if (!pass) mLock = 1'b0;
      mPass = 0;
    end else begin
      mPass = pass ? mPass + 1 : 0;
      if (mPass == 4) begin mLock = 1'b1; mPass = 0; end
    end
    uni = (w == 10'h3FF) || (w == 10'h000);
    pol = w[0];
    if (!uni) begin mCnt = 0; mLoss = 1'b0; end
    else if (mCnt > 0 && pol == mPol) begin if (mCnt < 12) mCnt++; end
    else begin mCnt = 1; mPol = pol; end
    if (mCnt == 12) mLoss = 1'b1;
  endtask

  // inputs change at negedge; outputs checked at the next negedge
  task automatic sendWord(input logic [9:0] w, input logic f, input string tag);
    wordValid = 1'b1; wordIn = w; freqOk = f;
    @(negedge clk);
    modelStep(w, f);
    wordValid = 1'b0;
    check(sigLoss, mLoss, tag, "sigLoss");
    check(lockData, mLock, tag, "lockData");
  endtask

  task automatic sendN(input int n, input logic [9:0] w, input logic f, input string tag);
    for (int i = 0; i < n; i++) sendWord(w, f, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; wordValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0; mPol = 0; mLoss = 0; mLock = 0; mPass = 0;
  endtask

  task automatic testReset();
    doReset();
    check(sigLoss, 1'b0, "R7", "reset sigLoss");
    check(lockData, 1'b0, "R7", "reset lockData");
  endtask

  task automatic testAligned();
    sendWord(10'h155, 1'b0, "R1");
    sendN(11, 10'h3FF, 1'b0, "R1");
    check(sigLoss, 1'b0, "R1", "after 11 ones");
    sendWord(10'h3FF, 1'b0, "R1");
    check(sigLoss, 1'b1, "R1", "after 12 ones");
    sendWord(10'h2AA, 1'b0, "R1");
    sendN(12, 10'h000, 1'b0, "R1");
    check(sigLoss, 1'b1, "R1", "after 12 zeros");
  endtask

  task automatic testPolarity();
    sendWord(10'h155, 1'b0, "R5");
    sendN(11, 10'h3FF, 1'b0, "R5");
    sendN(11, 10'h000, 1'b0, "R5");
    check(sigLoss, 1'b0, "R5", "11 ones then 11 zeros");
    sendWord(10'h000, 1'b0, "R5");
    check(sigLoss, 1'b1, "R5", "12th zero");
  endtask

  task automatic testSticky();
    sendWord(10'h155, 1'b0, "R6");
    sendN(12, 10'h3FF, 1'b0, "R6");
    sendWord(10'h000, 1'b0, "R6");
    check(sigLoss, 1'b1, "R6", "opposite uniform keeps loss");
    sendN(3, 10'h3FF, 1'b0, "R6");
    check(sigLoss, 1'b1, "R6", "more uniform keeps loss");
    sendWord(10'h1F0, 1'b0, "R6");
    check(sigLoss, 1'b0, "R6", "mixed clears");
    sendN(11, 10'h3FF, 1'b0, "R6");
    check(sigLoss, 1'b0, "R6", "count emptied by mixed");
  endtask

  function automatic logic bitAt(input int i, input int st, input int n, input logic b);
    if (i >= st && i < st + n) return b;
    if (i == st - 1 || i == st + n) return ~b;
    return logic'(i % 2);
  endfunction

  task automatic runSerial(input int n, input int off, input logic b, input string tag);
    int st, words, full;
    logic saw;
    logic [9:0] w;
    st = 20 + off;
    words = (st + n + 20 + 9) / 10;
    full = 0;
    saw = 1'b0;
    for (int k = 0; k < words; k++) begin
      for (int j = 0; j < 10; j++) w[j] = bitAt(10 * k + j, st, n, b);
      if (10 * k >= st && 10 * k + 9 < st + n) full++;
      sendWord(w, 1'b1, tag);
      if (sigLoss) saw = 1'b1;
    end
    check(saw, (full >= 12) ? 1'b1 : 1'b0, tag, $sformatf("run %0d off %0d", n, off));
  endtask

  task automatic testSerialBounds();
    for (int off = 0; off < 10; off++) runSerial(119, off, off[0], "R2");
    for (int off = 0; off < 10; off++) runSerial(129, off, ~off[0], "R3");
    runSerial(120, 0, 1'b1, "R4");
    runSerial(120, 1, 1'b0, "R4");
    runSerial(125, 5, 1'b1, "R4");
  endtask

  task automatic testLock();
    doReset();
    sendN(3, 10'h155, 1'b1, "R7");
    check(lockData, 1'b0, "R7", "3 passes not enough");
    sendWord(10'h155, 1'b0, "R7");
    sendN(3, 10'h155, 1'b1, "R7");
    check(lockData, 1'b0, "R7", "streak restarted");
    sendWord(10'h155, 1'b1, "R7");
    check(lockData, 1'b1, "R7", "locked after 4");
    sendWord(10'h155, 1'b0, "R8");
    check(lockData, 1'b0, "R8", "freq fail drops");
    sendN(4, 10'h155, 1'b1, "R8");
    check(lockData, 1'b1, "R8", "relocked");
    sendN(12, 10'h3FF, 1'b1, "R8");
    check(lockData, 1'b1, "R8", "loss set, not yet seen");
    sendWord(10'h3FF, 1'b1, "R8");
    check(lockData, 1'b0, "R8", "loss drops lock");
    sendWord(10'h155, 1'b1, "R7");
    sendN(3, 10'h155, 1'b1, "R7");
    check(lockData, 1'b0, "R7", "loss strobe did not pass");
    sendWord(10'h155, 1'b1, "R7");
    check(lockData, 1'b1, "R7", "relock after loss cleared");
  endtask

  task automatic testIdle();
    logic l0, s0;
    sendN(11, 10'h000, 1'b1, "R9");
    l0 = lockData; s0 = sigLoss;
    for (int i = 0; i < 6; i++) begin
      wordIn = (i % 2) ? 10'h000 : 10'h1A5;
      freqOk = i[0];
      @(negedge clk);
    end
    check(lockData, l0, "R9", "lock held idle");
    check(sigLoss, s0, "R9", "loss held idle");
    sendWord(10'h000, 1'b1, "R9");
    check(sigLoss, 1'b1, "R9", "run resumes to 12");
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    testReset();
    testAligned();
    testPolarity();
    testSticky();
    testSerialBounds();
    testLock();
    testIdle();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule